// File: doc/BRIEF.md
# Multi-lane pixel word serializer

This block turns one display pixel into a fixed 24-bit link word and shifts that word out over two or three serial data lanes. Alongside the data lanes it produces a forwarded clock lane. Each pixel carries 24-bit RGB colour plus the vertical sync, horizontal sync and data-enable bits. The colour is reduced to 6 bits per channel with a one-bit ordered dither. The link word then gets an odd-parity bit and a 2-bit rolling frame sequence count.

Everything runs on the serial clock `clk`. The block divides this clock into pixel periods: 4 serial cycles per pixel in 3-lane mode and 6 in 2-lane mode. It raises `pix_tick` in the last cycle of each period, and the pixel inputs are sampled at the rising edge that ends that cycle. Every lane, and the clock lane, is shown as a bit pair per serial cycle. Bit 0 of a pair goes out on the rising edge and bit 1 on the falling edge.

Pulling the active-low `pd_n` low idles every lane at once and drops the word being sent. When `pd_n` returns high, a fresh word is captured on the very next edge, and the dither and frame-sequence state start over.

Top module: `pixel_lane_serializer`

## Requirements
- R1: While powered, `pix_tick` is high in exactly one cycle of each pixel period, the period's last cycle, and the pixel inputs are sampled at the clock edge that ends that cycle. After power-up, or when `pd_n` is released, `pix_tick` goes high at once.
- R2: Each 8-bit channel is reduced to its 6 MSBs after adding a dither offset: 0 on even pixels and 2 on odd pixels. The sum saturates at 255. The first pixel after release counts as even, and the two alternate from then on.
- R3: `rgb_in` is {R[23:16], G[15:8], B[7:0]}. Link word bit fields are: R6 at [5:0], G6 at [11:6], B6 at [17:12], vsync [18], hsync [19], de [20], parity [21], and the frame sequence at [23:22].
- R4: The parity bit makes the count of ones over word bits [21:0] odd.
- R5: With `lane3_sel`=1 (sampled with the pixel) a pixel period is 4 serial cycles on lanes 0 to 2. With `lane3_sel`=0 it is 6 cycles on lanes 0 and 1, and lane 2 stays 00.
- R6: Lane k carries word bits k, k+L, k+2L, ... in increasing order (L = lane count). In phase p, the rising-edge bit is index (2p)·L+k and the falling-edge bit is (2p+1)·L+k. Lane k's pair sits at `lane_d[2k+1:2k]`, and phase 0 appears in the cycle after the sampling edge.
- R7: While a word is being sent, `clk_lane` is 2'b01 (high on the rising edge, low on the falling edge).
- R8: While `pd_n` is low, `clk_lane`, `lane_d` and `pix_tick` are all 0 in the same cycle. The word in flight is not resumed afterwards.
- R9: The frame sequence is 0 on the first word after release and goes up by one, modulo 4, on each later word.
- R10: While `rst` is high (synchronous, active high), and with `pd_n` low after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock (4x or 6x pixel rate) |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Active-low power-down |
| lane3_sel | input | 1 | 1 = three data lanes, 0 = two |
| rgb_in | input | 24 | Pixel colour {R,G,B}, 8 bits each |
| hsync_in | input | 1 | Horizontal sync |
| vsync_in | input | 1 | Vertical sync |
| de_in | input | 1 | Data enable |
| pix_tick | output | 1 | Pixel inputs sampled at the end of this cycle |
| clk_lane | output | 2 | Clock lane bit pair {falling, rising} |
| lane_d | output | 6 | Data lane bit pairs, lane k at [2k+1:2k] |

## Verification
The bench rebuilds each link word from the lane pairs and compares it with a word it computes on its own. The vectors switch between 2- and 3-lane modes, so a wrong lane stride or a wrong edge order would scramble bits. Odd-pixel vectors at 0xFF and 0xFE would wrap to 0 if saturation were missing, and 0x7E shows whether the dither offset is applied. Power-down is dropped in the middle of a word: an output that kept sending, or a sequence count that carried over past the release, would show up as idle-lane or frame-sequence mismatches.

// File: rtl/pls_pkg.sv
package pls_pkg;
    localparam int CH_W      = 8;
    localparam int RED_W     = 6;
    localparam int NUM_CH    = 3;
    localparam int MAX_LANES = 3;
    localparam int SEQ_W     = 2;
    localparam int COL_W     = NUM_CH * RED_W;
    localparam int WORD_W    = COL_W + 3 + 1 + SEQ_W;
    localparam int SLOTS_3   = WORD_W / (3 * 2);
    localparam int SLOTS_2   = WORD_W / (2 * 2);
    localparam int PH_W      = $clog2(SLOTS_2);
    localparam int DITH_ADD  = 1 << (CH_W - RED_W - 1);
    localparam int CH_MAX    = (1 << CH_W) - 1;

    typedef struct packed {
        logic [SEQ_W-1:0] fseq;
        logic             par;
        logic             de;
        logic             hs;
        logic             vs;
        logic [RED_W-1:0] b;
        logic [RED_W-1:0] g;
        logic [RED_W-1:0] r;
    } link_word_t;

    function automatic logic [RED_W-1:0] reduce_ch(input logic [CH_W-1:0] v, input logic odd);
        logic [CH_W:0] s;
        s = {1'b0, v} + (odd ? (CH_W+1)'(DITH_ADD) : '0);
        if (s > (CH_W+1)'(CH_MAX)) s = (CH_W+1)'(CH_MAX);
        return s[CH_W-1:CH_W-RED_W];
    endfunction

    function automatic logic odd_fill(input logic [COL_W+2:0] bits);
        return ~^bits;
    endfunction
endpackage

// File: rtl/pls_capture.sv
module pls_capture
    import pls_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 restart,
    input  logic                 lane3_sel,
    input  logic [NUM_CH*CH_W-1:0] rgb_in,
    input  logic                 hsync_in,
    input  logic                 vsync_in,
    input  logic                 de_in,
    output link_word_t           word_q,
    output logic                 mode3_q
);
    logic [SEQ_W-1:0]       fseq_q;
    logic                   dith_q;
    logic [SEQ_W-1:0]       f_use;
    logic                   d_use;
    logic [RED_W-1:0]       red [NUM_CH];
    link_word_t             word_d;

    assign f_use = restart ? '0 : fseq_q;
    assign d_use = restart ? 1'b0 : dith_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign red[c] = reduce_ch(rgb_in[(NUM_CH-c)*CH_W-1 -: CH_W], d_use);
    end

    always_comb begin
        word_d      = '0;
        word_d.r    = red[0];
        word_d.g    = red[1];
        word_d.b    = red[2];
        word_d.vs   = vsync_in;
        word_d.hs   = hsync_in;
        word_d.de   = de_in;
        word_d.par  = odd_fill({de_in, hsync_in, vsync_in, red[2], red[1], red[0]});
        word_d.fseq = f_use;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            mode3_q <= 1'b0;
            fseq_q  <= '0;
            dith_q  <= 1'b0;
        end else if (load) begin
            word_q  <= word_d;
            mode3_q <= lane3_sel;
            fseq_q  <= f_use + 1'b1;
            dith_q  <= ~d_use;
        end
    end
endmodule

// File: rtl/pls_distrib.sv
module pls_distrib
    import pls_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic                    drive,
    input  logic                    mode3,
    input  logic [WORD_W-1:0]       word,
    output logic                    phase_last,
    output logic [1:0]              clk_lane,
    output logic [2*MAX_LANES-1:0]  lane_d
);
    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || load) phase_q <= '0;
        else if (drive)  phase_q <= phase_q + 1'b1;
    end

    assign phase_last = mode3 ? (phase_q == PH_W'(SLOTS_3 - 1))
                              : (phase_q == PH_W'(SLOTS_2 - 1));
    assign clk_lane   = drive ? 2'b01 : 2'b00;

    always_comb begin
        int nl;
        int idx;
        nl     = mode3 ? 3 : 2;
        lane_d = '0;
        for (int k = 0; k < MAX_LANES; k++) begin
            for (int e = 0; e < 2; e++) begin
                idx = (2 * int'(phase_q) + e) * nl + k;
                if (drive && k < nl && idx < WORD_W)
                    lane_d[2*k+e] = word[idx];
            end
        end
    end
endmodule

// File: rtl/pixel_lane_serializer.sv
module pixel_lane_serializer
    import pls_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pd_n,
    input  logic        lane3_sel,
    input  logic [23:0] rgb_in,
    input  logic        hsync_in,
    input  logic        vsync_in,
    input  logic        de_in,
    output logic        pix_tick,
    output logic [1:0]  clk_lane,
    output logic [5:0]  lane_d
);
    logic              on_q;
    logic              phase_last;
    logic              mode3_q;
    link_word_t        word_s;
    logic [WORD_W-1:0] word_bits;

    assign pix_tick  = pd_n && !rst && (!on_q || phase_last);
    assign word_bits = word_s;

    always_ff @(posedge clk) begin
        if (rst || !pd_n) on_q <= 1'b0;
        else if (pix_tick) on_q <= 1'b1;
    end

    pls_capture u_cap (
        .clk(clk), .rst(rst), .load(pix_tick), .restart(!on_q),
        .lane3_sel(lane3_sel), .rgb_in(rgb_in), .hsync_in(hsync_in),
        .vsync_in(vsync_in), .de_in(de_in), .word_q(word_s), .mode3_q(mode3_q)
    );

    pls_distrib u_dist (
        .clk(clk), .rst(rst), .load(pix_tick), .drive(on_q && pd_n),
        .mode3(mode3_q), .word(word_bits), .phase_last(phase_last),
        .clk_lane(clk_lane), .lane_d(lane_d)
    );
endmodule

// File: rtl/pls_checker.sv
module pls_checker (
    input logic        clk,
    input logic        rst,
    input logic        pd_n,
    input logic        pix_tick,
    input logic [1:0]  clk_lane,
    input logic [5:0]  lane_d,
    input logic        on_q,
    input logic        mode3_q,
    input logic [23:0] word_bits
);
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
        (pix_tick && on_q) |=> !pix_tick);

    p_odd_parity_r4: assert property (@(posedge clk) disable iff (rst)
        on_q |-> ($countones(word_bits[21:0]) % 2 == 1));

    p_lane2_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !mode3_q |-> (lane_d[5:4] == 2'b00));

    p_clk_pattern_r7: assert property (@(posedge clk) disable iff (rst)
        (on_q && pd_n) |-> (clk_lane == 2'b01));

    p_off_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !pd_n |-> (lane_d == 6'd0 && clk_lane == 2'b00 && !pix_tick));

    p_seq_step_r9: assert property (@(posedge clk) disable iff (rst)
        (pix_tick && on_q) |=> (word_bits[23:22] == 2'($past(word_bits[23:22]) + 2'd1)));

    p_seq_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (pix_tick && !on_q) |=> (word_bits[23:22] == 2'd0));
endmodule

bind pixel_lane_serializer pls_checker u_chk (
    .clk(clk), .rst(rst), .pd_n(pd_n), .pix_tick(pix_tick),
    .clk_lane(clk_lane), .lane_d(lane_d), .on_q(on_q),
    .mode3_q(mode3_q), .word_bits(word_bits)
);

// File: tb/pixel_lane_serializer_tb.sv
module pixel_lane_serializer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pd_n = 1'b0;
    logic        lane3_sel = 1'b0;
    logic [23:0] rgb_in = '0;
    logic        hsync_in = 1'b0, vsync_in = 1'b0, de_in = 1'b0;
    logic        pix_tick;
    logic [1:0]  clk_lane;
    logic [5:0]  lane_d;

    int n_chk = 0;
    int n_bad = 0;
    logic [1:0] exp_seq = 2'd0;
    logic       exp_odd = 1'b0;

    always #2 clk = ~clk;

    pixel_lane_serializer u_dut (
        .clk(clk), .rst(rst), .pd_n(pd_n), .lane3_sel(lane3_sel),
        .rgb_in(rgb_in), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .de_in(de_in), .pix_tick(pix_tick), .clk_lane(clk_lane), .lane_d(lane_d)
    );

    // {lane3, vsync, hsync, de, rgb}
    localparam int NV = 10;
    localparam logic [27:0] VEC [NV] = '{
        {4'b1100, 24'h000000},
        {4'b1001, 24'hFFFFFF},
        {4'b0001, 24'h123456},
        {4'b0011, 24'h7E7E7E},
        {4'b1001, 24'h808080},
        {4'b0110, 24'h01FD03},
        {4'b1001, 24'hA5C3F0},
        {4'b1001, 24'hFE0280},
        {4'b0001, 24'h3C3C3C},
        {4'b1000, 24'h000000}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [5:0] red6(input logic [7:0] v, input logic odd);
        int s;
        s = int'(v) + (odd ? 2 : 0);
        if (s > 255) s = 255;
        return 6'(s >> 2);
    endfunction

    function automatic logic [23:0] model(input logic [27:0] v, input logic odd, input logic [1:0] f);
        logic [23:0] w;
        w = '0;
        w[5:0]   = red6(v[23:16], odd);
        w[11:6]  = red6(v[15:8], odd);
        w[17:12] = red6(v[7:0], odd);
        w[18] = v[26];
        w[19] = v[25];
        w[20] = v[24];
        w[21] = ~^w[20:0];
        w[23:22] = f;
        return w;
    endfunction

    // R1 R2 R3 R4 R5 R6 R7: send one pixel, rebuild the word from the lanes
    task automatic send(input logic [27:0] v);
        int nl, np;
        logic [23:0] got;
        while (!pix_tick) @(negedge clk);
        lane3_sel = v[27];
        vsync_in = v[26]; hsync_in = v[25]; de_in = v[24];
        rgb_in = v[23:0];
        nl = v[27] ? 3 : 2;
        np = v[27] ? 4 : 6;
        got = '0;
        for (int p = 0; p < np; p++) begin
            @(negedge clk);
            for (int k = 0; k < nl; k++)
                for (int e = 0; e < 2; e++)
                    got[(2*p+e)*nl+k] = lane_d[2*k+e];
            check("R7 clock lane", 32'(clk_lane), 32'h1);
            check("R1 tick position", 32'(pix_tick), 32'(p == np-1));
            if (!v[27]) check("R5 lane2 idle", 32'(lane_d[5:4]), 32'h0);
        end
        check("R2 R3 R4 R6 R9 word", 32'(got), 32'(model(v, exp_odd, exp_seq)));
        exp_seq = exp_seq + 2'd1;
        exp_odd = ~exp_odd;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset lanes", 32'(lane_d), 32'h0);
        check("R10 reset clk", 32'(clk_lane), 32'h0);
        check("R10 reset tick", 32'(pix_tick), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R10 off tick", 32'(pix_tick), 32'h0);
        pd_n = 1'b1;
        #1 check("R1 tick on release", 32'(pix_tick), 32'h1);

        for (int i = 0; i < NV; i++) send(VEC[i]);

        // R8: drop power mid-word
        while (!pix_tick) @(negedge clk);
        lane3_sel = 1'b1; rgb_in = 24'hFFFFFF; de_in = 1'b1;
        repeat (2) @(negedge clk);
        pd_n = 1'b0;
        #1;
        check("R8 lanes idle", 32'(lane_d), 32'h0);
        check("R8 clock idle", 32'(clk_lane), 32'h0);
        check("R8 tick idle", 32'(pix_tick), 32'h0);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check("R8 stays idle", 32'({clk_lane, lane_d, pix_tick}), 32'h0);
        end
        pd_n = 1'b1;
        exp_seq = 2'd0;
        exp_odd = 1'b0;
        #1 check("R1 R9 restart tick", 32'(pix_tick), 32'h1);
        send({4'b1011, 24'h7E7E7E});
        send({4'b0001, 24'hFFFEFD});
        send({4'b1100, 24'h0A0B0C});

        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule